// File: doc/BRIEF.md
# Backward address-slice detection unit

This front-end unit learns which non-memory micro-ops feed the address of a load or a store. It keeps a small tag-only table of instruction pointers known to be address generators and a table with one entry per physical register, which records the pointer of the op that last wrote that register and whether that op was already marked. At fetch, each lookup port reports whether an instruction pointer is marked. The front end carries that bit down to rename, where it steers the op to the bypass path.

At rename, the unit records each op as the writer of its destination register. When the renamed op is a load, a store, or an op that arrived marked, the unit looks up the writers of its address sources. Every writer that is not yet marked is inserted into the tag table. Because only the direct producers are added, the slice grows backward by one producer level per loop iteration. An op that is already in flight is never reclassified: only later fetches of the same pointer see the new mark.

The unit has two lookup ports and two rename ports per cycle, and each rename port carries up to three sources. Inserts that fall in the same cycle are applied in lane-then-source order. An insert of a tag that is already present only refreshes that set's replacement state.

Top module: `addr_slice_detect`

## Requirements
- R1: After reset the tag table is empty and every register entry is unwritten. No lookup hits, and a source register that has not been written since reset causes no insert.
- R2: `fq_hit[l]` is 1 only when `fq_valid[l]` is 1 and the pointer's tag is held in its set. The two lookup ports give the same answer for the same pointer in the same cycle.
- R3: A valid rename with `rn_dst_en` set records the op's pointer as the writer of `rn_dst`. It also records a mark bit that is set when `rn_marked` is 1 or when the op is a load or a store.
- R4: When the renamed op is a load (kind 2'b01), a store (kind 2'b10), or arrives with `rn_marked` = 1, the recorded writer of each enabled source is inserted if that writer's mark bit is clear.
- R5: An op of execute kind (2'b00, with 2'b11 treated the same way) that arrives unmarked inserts nothing.
- R6: For a store, source slot 2 carries the data operand and is never followed. Slots 0 and 1 are address operands.
- R7: The pointer of a load or a store is never inserted, even when it is the producer of an address source.
- R8: The set index is instruction-pointer bits [7:2] (64 sets). The remaining upper 24 bits form the tag.
- R9: Each set has two ways. An insert that misses fills an empty way first; otherwise it replaces the least recently inserted or refreshed way.
- R10: An insert whose tag is already present allocates nothing and makes that way the most recently used.
- R11: Within one cycle, lane 1 sees lane 0's destination write as the newest writer. Inserts are applied in the order lane 0 sources 0 to 2, then lane 1 sources 0 to 2, so same-set inserts in one cycle are serialised and duplicates merge.
- R12: A lookup sees an insert only from the cycle after the rename edge that made it, and the table changes only through rename.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fq_valid | input | LANES | Lookup request per fetch lane |
| fq_ip | input | LANES*IP_W | Instruction pointer per fetch lane, lane 0 in the low bits |
| fq_hit | output | LANES | Pointer is a known address generator |
| rn_valid | input | LANES | Rename slot carries an op |
| rn_ip | input | LANES*IP_W | Pointer of the renamed op |
| rn_kind | input | LANES*2 | Op kind: 00 execute, 01 load, 10 store, 11 treated as execute |
| rn_marked | input | LANES | Fetch-time hit bit carried with the op |
| rn_dst_en | input | LANES | Op writes a destination register |
| rn_dst | input | LANES*PR_W | Physical destination register |
| rn_src_en | input | LANES*NSRC | Source slot in use |
| rn_src | input | LANES*NSRC*PR_W | Physical source registers, lane-major |

## Verification
A stale or corrupted writer entry shows up one loop iteration later. The wrong producer gets marked, or the right one does not, and this appears as a wrong `fq_hit` on the next fetch of that pointer. A replacement-state fault stays hidden until a third distinct tag enters a two-way set; the victim choice then exposes it on the first lookup after that insert. A fault in same-cycle forwarding between lanes or in insert ordering is only visible when both rename lanes touch the same register or the same set in one cycle. The directed tests set up exactly that case and look one cycle later.

// File: rtl/asd_pkg.sv
package asd_pkg;

    typedef enum logic [1:0] {
        OP_EXEC  = 2'b00,
        OP_LOAD  = 2'b01,
        OP_STORE = 2'b10,
        OP_RSVD  = 2'b11
    } op_kind_e;

endpackage

// File: rtl/asd_writer_table.sv
module asd_writer_table
    import asd_pkg::*;
#(
    parameter int IP_W  = 32,
    parameter int NPREG = 64,
    parameter int LANES = 2,
    parameter int NSRC  = 3,
    localparam int PR_W  = $clog2(NPREG),
    localparam int NCAND = LANES * NSRC
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [LANES-1:0]                       rn_valid,
    input  logic [LANES-1:0][IP_W-1:0]             rn_ip,
    input  logic [LANES-1:0][1:0]                  rn_kind,
    input  logic [LANES-1:0]                       rn_marked,
    input  logic [LANES-1:0]                       rn_dst_en,
    input  logic [LANES-1:0][PR_W-1:0]             rn_dst,
    input  logic [LANES-1:0][NSRC-1:0]             rn_src_en,
    input  logic [LANES-1:0][NSRC-1:0][PR_W-1:0]   rn_src,
    output logic [NCAND-1:0]                       cand_vld,
    output logic [NCAND-1:0][IP_W-1:0]             cand_ip
);

    logic [IP_W-1:0] wip_q  [NPREG];
    logic            wmk_q  [NPREG];
    logic            wvld_q [NPREG];

    logic [LANES-1:0] follow;
    logic [LANES-1:0] wr_mark;
    logic [LANES-1:0] is_store;

    // Per-lane classification: which ops chase their sources, and the mark they leave.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            is_store[l] = (op_kind_e'(rn_kind[l]) == OP_STORE);
            wr_mark[l]  = rn_marked[l] || is_store[l] ||
                          (op_kind_e'(rn_kind[l]) == OP_LOAD);
            follow[l]   = rn_valid[l] && wr_mark[l];
        end
    end

    // Producer lookup with forwarding from older lanes of the same cycle.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            for (int s = 0; s < NSRC; s++) begin
                logic [IP_W-1:0] p_ip;
                logic            p_mk;
                logic            p_v;
                p_ip = wip_q[rn_src[l][s]];
                p_mk = wmk_q[rn_src[l][s]];
                p_v  = wvld_q[rn_src[l][s]];
                for (int j = 0; j < l; j++) begin
                    if (rn_valid[j] && rn_dst_en[j] && (rn_dst[j] == rn_src[l][s])) begin
                        p_ip = rn_ip[j];
                        p_mk = wr_mark[j];
                        p_v  = 1'b1;
                    end
                end
                cand_ip[l*NSRC+s]  = p_ip;
                cand_vld[l*NSRC+s] = follow[l] && rn_src_en[l][s] && p_v && !p_mk &&
                                     !(is_store[l] && (s == NSRC-1));
            end
        end
    end

    // Writer records; a later lane overrides an earlier one on the same register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NPREG; p++) begin
                wip_q[p]  <= '0;
                wmk_q[p]  <= 1'b0;
                wvld_q[p] <= 1'b0;
            end
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (rn_valid[l] && rn_dst_en[l]) begin
                    wip_q[rn_dst[l]]  <= rn_ip[l];
                    wmk_q[rn_dst[l]]  <= wr_mark[l];
                    wvld_q[rn_dst[l]] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/asd_slice_table.sv
module asd_slice_table #(
    parameter int IP_W     = 32,
    parameter int SETS     = 64,
    parameter int IP_SHIFT = 2,
    parameter int LANES    = 2,
    parameter int NCAND    = 6,
    localparam int IDX_W   = $clog2(SETS),
    localparam int TAG_W   = IP_W - IP_SHIFT - IDX_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANES-1:0]            lk_vld,
    input  logic [LANES-1:0][IP_W-1:0]  lk_ip,
    output logic [LANES-1:0]            lk_hit,
    input  logic [NCAND-1:0]            ins_vld,
    input  logic [NCAND-1:0][IP_W-1:0]  ins_ip
);

    logic [TAG_W-1:0] tag_q [SETS][2];
    logic             vld_q [SETS][2];
    logic             lru_q [SETS];     // way to replace next
    logic [TAG_W-1:0] tag_d [SETS][2];
    logic             vld_d [SETS][2];
    logic             lru_d [SETS];

    // Lookup ports read the registered table only.
    for (genvar l = 0; l < LANES; l++) begin : g_lookup
        logic [IDX_W-1:0] s;
        logic [TAG_W-1:0] t;
        assign s = lk_ip[l][IP_SHIFT +: IDX_W];
        assign t = lk_ip[l][IP_W-1 -: TAG_W];
        assign lk_hit[l] = lk_vld[l] &&
                           ((vld_q[s][0] && (tag_q[s][0] == t)) ||
                            (vld_q[s][1] && (tag_q[s][1] == t)));
    end

    // Inserts applied in candidate order on a running copy of the table.
    always_comb begin
        logic [IDX_W-1:0] s;
        logic [TAG_W-1:0] t;
        logic             h0, h1, way;
        tag_d = tag_q;
        vld_d = vld_q;
        lru_d = lru_q;
        s = '0; t = '0; h0 = 1'b0; h1 = 1'b0; way = 1'b0;
        for (int k = 0; k < NCAND; k++) begin
            if (ins_vld[k]) begin
                s  = ins_ip[k][IP_SHIFT +: IDX_W];
                t  = ins_ip[k][IP_W-1 -: TAG_W];
                h0 = vld_d[s][0] && (tag_d[s][0] == t);
                h1 = vld_d[s][1] && (tag_d[s][1] == t);
                if (h0) begin
                    lru_d[s] = 1'b1;
                end else if (h1) begin
                    lru_d[s] = 1'b0;
                end else begin
                    if (!vld_d[s][0])      way = 1'b0;
                    else if (!vld_d[s][1]) way = 1'b1;
                    else                   way = lru_d[s];
                    tag_d[s][way] = t;
                    vld_d[s][way] = 1'b1;
                    lru_d[s]      = ~way;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                tag_q[i][0] <= '0;
                tag_q[i][1] <= '0;
                vld_q[i][0] <= 1'b0;
                vld_q[i][1] <= 1'b0;
                lru_q[i]    <= 1'b0;
            end
        end else begin
            tag_q <= tag_d;
            vld_q <= vld_d;
            lru_q <= lru_d;
        end
    end

endmodule

// File: rtl/addr_slice_detect.sv
module addr_slice_detect #(
    parameter int IP_W     = 32,
    parameter int SETS     = 64,
    parameter int IP_SHIFT = 2,
    parameter int NPREG    = 64,
    parameter int LANES    = 2,
    parameter int NSRC     = 3,
    localparam int PR_W    = $clog2(NPREG),
    localparam int NCAND   = LANES * NSRC
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANES-1:0]              fq_valid,
    input  logic [LANES*IP_W-1:0]         fq_ip,
    output logic [LANES-1:0]              fq_hit,
    input  logic [LANES-1:0]              rn_valid,
    input  logic [LANES*IP_W-1:0]         rn_ip,
    input  logic [LANES*2-1:0]            rn_kind,
    input  logic [LANES-1:0]              rn_marked,
    input  logic [LANES-1:0]              rn_dst_en,
    input  logic [LANES*PR_W-1:0]         rn_dst,
    input  logic [LANES*NSRC-1:0]         rn_src_en,
    input  logic [LANES*NSRC*PR_W-1:0]    rn_src
);

    logic [LANES-1:0][IP_W-1:0]            fq_ip_a;
    logic [LANES-1:0][IP_W-1:0]            rn_ip_a;
    logic [LANES-1:0][1:0]                 rn_kind_a;
    logic [LANES-1:0][PR_W-1:0]            rn_dst_a;
    logic [LANES-1:0][NSRC-1:0]            rn_src_en_a;
    logic [LANES-1:0][NSRC-1:0][PR_W-1:0]  rn_src_a;
    logic [NCAND-1:0]                      cand_vld;
    logic [NCAND-1:0][IP_W-1:0]            cand_ip;

    assign fq_ip_a     = fq_ip;
    assign rn_ip_a     = rn_ip;
    assign rn_kind_a   = rn_kind;
    assign rn_dst_a    = rn_dst;
    assign rn_src_en_a = rn_src_en;
    assign rn_src_a    = rn_src;

    asd_writer_table #(
        .IP_W (IP_W),
        .NPREG(NPREG),
        .LANES(LANES),
        .NSRC (NSRC)
    ) u_writers (
        .clk      (clk),
        .rst_n    (rst_n),
        .rn_valid (rn_valid),
        .rn_ip    (rn_ip_a),
        .rn_kind  (rn_kind_a),
        .rn_marked(rn_marked),
        .rn_dst_en(rn_dst_en),
        .rn_dst   (rn_dst_a),
        .rn_src_en(rn_src_en_a),
        .rn_src   (rn_src_a),
        .cand_vld (cand_vld),
        .cand_ip  (cand_ip)
    );

    asd_slice_table #(
        .IP_W    (IP_W),
        .SETS    (SETS),
        .IP_SHIFT(IP_SHIFT),
        .LANES   (LANES),
        .NCAND   (NCAND)
    ) u_slices (
        .clk    (clk),
        .rst_n  (rst_n),
        .lk_vld (fq_valid),
        .lk_ip  (fq_ip_a),
        .lk_hit (fq_hit),
        .ins_vld(cand_vld),
        .ins_ip (cand_ip)
    );

endmodule

// File: rtl/addr_slice_detect_chk.sv
module addr_slice_detect_chk #(
    parameter int IP_W     = 32,
    parameter int SETS     = 64,
    parameter int IP_SHIFT = 2,
    parameter int NPREG    = 64,
    parameter int LANES    = 2,
    parameter int NSRC     = 3,
    localparam int PR_W    = $clog2(NPREG)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANES-1:0]              fq_valid,
    input  logic [LANES*IP_W-1:0]         fq_ip,
    input  logic [LANES-1:0]              fq_hit,
    input  logic [LANES-1:0]              rn_valid,
    input  logic [LANES*IP_W-1:0]         rn_ip,
    input  logic [LANES*2-1:0]            rn_kind,
    input  logic [LANES-1:0]              rn_marked,
    input  logic [LANES-1:0]              rn_dst_en,
    input  logic [LANES*PR_W-1:0]         rn_dst,
    input  logic [LANES*NSRC-1:0]         rn_src_en,
    input  logic [LANES*NSRC*PR_W-1:0]    rn_src
);

    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (fq_hit == '0)); // R1

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            !fq_valid[l] |-> !fq_hit[l]); // R2
    end

    if (LANES >= 2) begin : g_pair
        AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
            (fq_valid[1:0] == 2'b11 && fq_ip[IP_W-1:0] == fq_ip[2*IP_W-1:IP_W])
            |-> (fq_hit[0] == fq_hit[1])); // R2
    end

    AST_IDLE_TABLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rn_valid == '0) |=>
        (!($stable(fq_ip) && $stable(fq_valid)) || $stable(fq_hit))); // R12

endmodule

bind addr_slice_detect addr_slice_detect_chk #(
    .IP_W    (IP_W),
    .SETS    (SETS),
    .IP_SHIFT(IP_SHIFT),
    .NPREG   (NPREG),
    .LANES   (LANES),
    .NSRC    (NSRC)
) u_chk (.*);

// File: tb/test_addr_slice_detect.sv
module test_addr_slice_detect;

    localparam logic [1:0] K_EX = 2'b00;
    localparam logic [1:0] K_LD = 2'b01;
    localparam logic [1:0] K_ST = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [1:0]            fq_valid;
    logic [1:0][31:0]      fq_ip;
    logic [1:0]            fq_hit;
    logic [1:0]            rn_valid;
    logic [1:0][31:0]      rn_ip;
    logic [1:0][1:0]       rn_kind;
    logic [1:0]            rn_marked;
    logic [1:0]            rn_dst_en;
    logic [1:0][5:0]       rn_dst;
    logic [1:0][2:0]       rn_src_en;
    logic [1:0][2:0][5:0]  rn_src;

    addr_slice_detect i_addr_slice_detect (
        .clk(clk), .rst_n(rst_n),
        .fq_valid(fq_valid), .fq_ip(fq_ip), .fq_hit(fq_hit),
        .rn_valid(rn_valid), .rn_ip(rn_ip), .rn_kind(rn_kind),
        .rn_marked(rn_marked), .rn_dst_en(rn_dst_en), .rn_dst(rn_dst),
        .rn_src_en(rn_src_en), .rn_src(rn_src)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic        v;
        logic [1:0]  kind;
        logic [31:0] ip;
        logic        mk;
        logic        de;
        logic [5:0]  dst;
        logic [2:0]  se;
        logic [5:0]  s0;
        logic [5:0]  s1;
        logic [5:0]  s2;
        logic [31:0] lk;
        logic        exp;
    } vec_t;

    // Lane-0 rename per cycle; lk is looked up before that cycle's edge.
    localparam vec_t VEC [0:18] = '{
        '{1'b1, K_EX, 32'h100, 1'b0, 1'b1, 6'd1,  3'b000, 6'd0,  6'd0, 6'd0, 32'h100, 1'b0},
        '{1'b1, K_EX, 32'h104, 1'b0, 1'b1, 6'd2,  3'b001, 6'd1,  6'd0, 6'd0, 32'h104, 1'b0},
        '{1'b1, K_LD, 32'h108, 1'b0, 1'b1, 6'd3,  3'b001, 6'd2,  6'd0, 6'd0, 32'h108, 1'b0}, // R4 insert 104
        '{1'b1, K_EX, 32'h100, 1'b0, 1'b1, 6'd1,  3'b000, 6'd0,  6'd0, 6'd0, 32'h100, 1'b0},
        '{1'b1, K_EX, 32'h104, 1'b1, 1'b1, 6'd2,  3'b001, 6'd1,  6'd0, 6'd0, 32'h104, 1'b1}, // R4 R12 marked
        '{1'b1, K_LD, 32'h108, 1'b0, 1'b1, 6'd3,  3'b001, 6'd2,  6'd0, 6'd0, 32'h108, 1'b0}, // R3 marked writer
        '{1'b0, K_EX, 32'h0,   1'b0, 1'b0, 6'd0,  3'b000, 6'd0,  6'd0, 6'd0, 32'h100, 1'b1}, // R4 second level
        '{1'b1, K_EX, 32'h200, 1'b0, 1'b1, 6'd5,  3'b000, 6'd0,  6'd0, 6'd0, 32'h200, 1'b0},
        '{1'b1, K_EX, 32'h204, 1'b0, 1'b1, 6'd6,  3'b000, 6'd0,  6'd0, 6'd0, 32'h204, 1'b0},
        '{1'b1, K_ST, 32'h208, 1'b0, 1'b0, 6'd0,  3'b101, 6'd5,  6'd0, 6'd6, 32'h208, 1'b0},
        '{1'b0, K_EX, 32'h0,   1'b0, 1'b0, 6'd0,  3'b000, 6'd0,  6'd0, 6'd0, 32'h200, 1'b1}, // R6 address side
        '{1'b0, K_EX, 32'h0,   1'b0, 1'b0, 6'd0,  3'b000, 6'd0,  6'd0, 6'd0, 32'h204, 1'b0}, // R6 data side
        '{1'b1, K_EX, 32'h300, 1'b0, 1'b1, 6'd7,  3'b000, 6'd0,  6'd0, 6'd0, 32'h300, 1'b0},
        '{1'b1, K_EX, 32'h304, 1'b0, 1'b1, 6'd8,  3'b001, 6'd7,  6'd0, 6'd0, 32'h304, 1'b0},
        '{1'b0, K_EX, 32'h0,   1'b0, 1'b0, 6'd0,  3'b000, 6'd0,  6'd0, 6'd0, 32'h300, 1'b0}, // R5
        '{1'b1, K_LD, 32'h400, 1'b0, 1'b1, 6'd9,  3'b000, 6'd0,  6'd0, 6'd0, 32'h400, 1'b0},
        '{1'b1, K_LD, 32'h404, 1'b0, 1'b1, 6'd10, 3'b001, 6'd9,  6'd0, 6'd0, 32'h404, 1'b0},
        '{1'b0, K_EX, 32'h0,   1'b0, 1'b0, 6'd0,  3'b000, 6'd0,  6'd0, 6'd0, 32'h400, 1'b0}, // R7
        '{1'b1, K_LD, 32'h500, 1'b0, 1'b0, 6'd0,  3'b001, 6'd20, 6'd0, 6'd0, 32'h0,   1'b0}  // R1 unwritten src
    };

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic clr();
        rn_valid = '0; rn_ip = '0; rn_kind = '0; rn_marked = '0;
        rn_dst_en = '0; rn_dst = '0; rn_src_en = '0; rn_src = '0;
    endtask

    task automatic ren(input int l, input logic [1:0] k, input logic [31:0] ip,
                       input logic de, input logic [5:0] d, input logic [2:0] se,
                       input logic [5:0] a, input logic [5:0] b);
        rn_valid[l] = 1'b1; rn_ip[l] = ip; rn_kind[l] = k; rn_marked[l] = 1'b0;
        rn_dst_en[l] = de; rn_dst[l] = d; rn_src_en[l] = se;
        rn_src[l][0] = a; rn_src[l][1] = b; rn_src[l][2] = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic look(input int l, input logic [31:0] ip, input logic exp, input string tag);
        fq_valid[l] = 1'b1;
        fq_ip[l] = ip;
        #2;
        chk(fq_hit[l], exp, tag);
    endtask

    // Teach one pointer: execute op writes p30, then a load reads p30.
    task automatic teach(input logic [31:0] ip);
        clr();
        ren(0, K_EX, ip, 1'b1, 6'd30, 3'b000, 6'd0, 6'd0);
        tick();
        clr();
        ren(0, K_LD, 32'hF00, 1'b0, 6'd0, 3'b001, 6'd30, 6'd0);
        tick();
        clr();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        clr();
        fq_valid = '0;
        fq_ip = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        look(0, 32'h100, 1'b0, "R1 reset lookup lane0");
        look(1, 32'h0,   1'b0, "R1 reset lookup lane1");

        // Table walk: chain, store data operand, unmarked op, load producer
        for (int i = 0; i < 19; i++) begin
            clr();
            rn_valid[0] = VEC[i].v;
            rn_kind[0] = VEC[i].kind;
            rn_ip[0] = VEC[i].ip;
            rn_marked[0] = VEC[i].mk;
            rn_dst_en[0] = VEC[i].de;
            rn_dst[0] = VEC[i].dst;
            rn_src_en[0] = VEC[i].se;
            rn_src[0][0] = VEC[i].s0;
            rn_src[0][1] = VEC[i].s1;
            rn_src[0][2] = VEC[i].s2;
            fq_valid[0] = 1'b1;
            fq_ip[0] = VEC[i].lk;
            #2;
            n_chk++;
            if (fq_hit[0] !== VEC[i].exp) begin
                n_bad++;
                $display("FAIL vector %0d (R3 R4 R5 R6 R7 table): actual %0b expected %0b",
                         i, fq_hit[0], VEC[i].exp);
            end
            tick();
        end
        clr();
        look(0, 32'h0, 1'b0, "R1 unwritten source inserted nothing");

        // R11 R12: lane 1 load consumes lane 0 result in the same cycle
        ren(0, K_EX, 32'h6C0, 1'b1, 6'd40, 3'b000, 6'd0, 6'd0);
        ren(1, K_LD, 32'hF04, 1'b0, 6'd0, 3'b001, 6'd40, 6'd0);
        look(1, 32'h6C0, 1'b0, "R12 same-cycle lookup sees old table");
        tick();
        clr();
        look(1, 32'h6C0, 1'b1, "R11 lane forwarding inserted producer");

        // R11: two inserts into one set plus a duplicate in one cycle
        ren(0, K_EX, 32'h780, 1'b1, 6'd41, 3'b000, 6'd0, 6'd0);
        ren(1, K_EX, 32'h880, 1'b1, 6'd42, 3'b000, 6'd0, 6'd0);
        tick();
        clr();
        ren(0, K_LD, 32'hF08, 1'b0, 6'd0, 3'b011, 6'd41, 6'd42);
        ren(1, K_LD, 32'hF0C, 1'b0, 6'd0, 3'b001, 6'd41, 6'd0);
        tick();
        clr();
        look(0, 32'h780, 1'b1, "R11 same-set insert first");
        look(1, 32'h880, 1'b1, "R11 same-set insert second");
        look(1, 32'h780, 1'b1, "R2 both ports agree");
        fq_valid[0] = 1'b0;
        #2;
        chk(fq_hit[0], 1'b0, "R2 hit needs valid");

        // R8 R9 R10: replacement inside set 0x10
        teach(32'h040);
        teach(32'h140);
        teach(32'h040);
        teach(32'h240);
        look(0, 32'h040, 1'b1, "R10 refreshed way kept");
        look(0, 32'h140, 1'b0, "R9 LRU way evicted");
        look(0, 32'h240, 1'b1, "R8 new tag placed");
        teach(32'h340);
        look(0, 32'h040, 1'b0, "R9 older way evicted");
        look(0, 32'h240, 1'b1, "R9 recent way kept");
        look(0, 32'h340, 1'b1, "R9 new tag placed");
        look(0, 32'h104, 1'b1, "R8 other set untouched");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule